// File: doc/BRIEF.md
# SPI Command Frame Encoder

This block turns one host command for a wireless-chip SPI slave into the byte sequence that goes on the wire. A command is given as an opcode, a 24-bit address, a 32-bit data word, a 24-bit transfer size, a clockless flag and a CRC-enable flag. The encoder decodes the opcode into a frame layout, packs the fields most significant byte first, and streams the bytes to a byte-wide serializer through a valid/ready handshake.

While the bytes leave, a CRC7 is accumulated over them. When CRC is enabled, a trailing byte is appended that holds the CRC in its upper seven bits with a zero least significant bit. When CRC is disabled, that byte is left off and the frame is one byte shorter. Opcodes outside the supported set produce a single-cycle error pulse and put no byte on the output.

Top module: `spicmd_frame_enc`

## Requirements
- R1: After reset, cmd_ready is 1 and byte_valid, byte_last, frame_done and cmd_err are 0. A command is taken on a cycle with cmd_valid and cmd_ready both high. cmd_ready stays 0 from the cycle after acceptance until the last byte of the frame has been taken.
- R2: Opcode 0xCA (single read) sends the opcode followed by address bits 23:16, 15:8 and 7:0. Opcode 0xC9 (single write) sends the same four bytes followed by the data word from bits 31:24 down to bits 7:0. Byte 0 of every frame is the opcode.
- R3: Opcodes 0xC4 (internal read) and 0xC3 (internal write) send the opcode, then address bits 15:8 with bit 7 forced to 1 when cmd_clockless is 1, then address bits 7:0. Internal read then sends one 0x00 byte. Internal write then sends the data word, most significant byte first.
- R4: Opcodes 0xC5 (terminate) and 0xC6 (repeat) send the opcode followed by three 0x00 bytes. Opcode 0xCF (reset) sends the opcode followed by three 0xFF bytes.
- R5: Opcodes 0xC1 and 0xC2 send the opcode, the 24-bit address and size bits 15:8 and 7:0. Opcodes 0xC7 and 0xC8 send the opcode, the 24-bit address and size bits 23:16, 15:8 and 7:0.
- R6: With cmd_crc_en at 1, one more byte follows the fields. This byte equals {crc, 1'b0}, where crc is a CRC7 with generator x^7+x^3+1 and seed 0x7F, taken MSB first over every earlier byte of the frame.
- R7: With cmd_crc_en at 0, the frame ends after the last field byte, so it is one byte shorter than the same command with CRC.
- R8: An opcode outside the eleven supported values raises cmd_err for exactly one cycle, in the cycle after acceptance. No byte is sent, and cmd_ready stays 1.
- R9: While byte_valid is 1 and byte_ready is 0, byte_valid, byte_data and byte_last hold their values into the next cycle.
- R10: byte_last is 1 only with the final byte of a frame. frame_done is 1 for exactly the one cycle after that byte is taken, and byte_valid is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Encoder idle, can take a command |
| cmd_op | input | 8 | Command opcode |
| cmd_addr | input | 24 | Target address |
| cmd_data | input | 32 | Data word for write commands |
| cmd_size | input | 24 | Transfer size for DMA commands |
| cmd_clockless | input | 1 | Sets bit 7 of the high internal-address byte |
| cmd_crc_en | input | 1 | Append the CRC7 byte |
| cmd_err | output | 1 | One-cycle pulse for an unsupported opcode |
| byte_valid | output | 1 | Frame byte available |
| byte_ready | input | 1 | Serializer takes the byte |
| byte_data | output | 8 | Frame byte |
| byte_last | output | 1 | Final byte of the frame |
| frame_done | output | 1 | One-cycle pulse after the final byte is taken |

## Verification
The bench builds the expected frame for every layout from the field rules and computes the CRC7 bit by bit on its own. It then compares each byte as it is taken, with CRC on and with CRC off. The clockless bit is driven both with address bit 15 clear and with it set. This catches a design that ORs the bit into the wrong byte, or that ignores it when the address already has the bit. Size fields are driven with nonzero upper bits, so a short DMA layout that leaks size bits 23:16 into the frame shows up as an extra or shifted byte. Stalls on byte_ready are placed on the CRC byte and the field bytes to expose a CRC register that advances on a stalled cycle. Opcodes on both sides of the valid set (0xC0, 0xCB, 0xCE) check that a gap in the decoder does not launch a frame.

// File: rtl/spicmd_pkg.sv
// Package: shared widths, opcode codes and frame layout classes for the
// SPI command frame encoder. All frame geometry derives from these values.
package spicmd_pkg;
    localparam int BYTE_W     = 8;
    localparam int ADDR_W     = 24;
    localparam int WORD_W     = 32;
    localparam int SIZE_W     = 24;
    localparam int WORD_BYTES = WORD_W / BYTE_W;
    localparam int FRAME_MAX  = 1 + (ADDR_W / BYTE_W) + WORD_BYTES + 1;
    localparam int IDX_W      = $clog2(FRAME_MAX + 1);
    localparam int CRC_W      = 7;
    localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;
    localparam logic [CRC_W-1:0] CRC_SEED = 7'h7F;

    localparam logic [BYTE_W-1:0] OP_DMA_WR   = 8'hC1;
    localparam logic [BYTE_W-1:0] OP_DMA_RD   = 8'hC2;
    localparam logic [BYTE_W-1:0] OP_INT_WR   = 8'hC3;
    localparam logic [BYTE_W-1:0] OP_INT_RD   = 8'hC4;
    localparam logic [BYTE_W-1:0] OP_TERM     = 8'hC5;
    localparam logic [BYTE_W-1:0] OP_REPEAT   = 8'hC6;
    localparam logic [BYTE_W-1:0] OP_XDMA_WR  = 8'hC7;
    localparam logic [BYTE_W-1:0] OP_XDMA_RD  = 8'hC8;
    localparam logic [BYTE_W-1:0] OP_SGL_WR   = 8'hC9;
    localparam logic [BYTE_W-1:0] OP_SGL_RD   = 8'hCA;
    localparam logic [BYTE_W-1:0] OP_RESET    = 8'hCF;

    typedef enum logic [3:0] {
        LAY_BAD,
        LAY_ADDR24,
        LAY_INT_RD,
        LAY_ZERO3,
        LAY_ONES3,
        LAY_DMA16,
        LAY_DMA24,
        LAY_INT_WR,
        LAY_SGL_WR
    } layout_e;

    typedef logic [FRAME_MAX-1:0][BYTE_W-1:0] frame_t;
endpackage

// File: rtl/spicmd_opdec.sv
// Opcode decoder: maps a command opcode to a frame layout class.
// Assumes: purely combinational. Unsupported opcodes map to LAY_BAD with known low.
module spicmd_opdec
    import spicmd_pkg::*;
(
    input  logic [BYTE_W-1:0] op,
    output layout_e           layout,
    output logic              known
);
    // Select the layout class for the opcode.
    always_comb begin
        unique case (op)
            OP_SGL_RD:              layout = LAY_ADDR24;
            OP_SGL_WR:              layout = LAY_SGL_WR;
            OP_INT_RD:              layout = LAY_INT_RD;
            OP_INT_WR:              layout = LAY_INT_WR;
            OP_TERM, OP_REPEAT:     layout = LAY_ZERO3;
            OP_RESET:               layout = LAY_ONES3;
            OP_DMA_WR, OP_DMA_RD:   layout = LAY_DMA16;
            OP_XDMA_WR, OP_XDMA_RD: layout = LAY_DMA24;
            default:                layout = LAY_BAD;
        endcase
    end

    // Flag a supported opcode.
    always_comb known = (layout != LAY_BAD);
endmodule

// File: rtl/spicmd_pack.sv
// Field packer: places opcode, address, size and data into frame byte slots,
// most significant byte first, and reports the field byte count (no CRC).
// Assumes: combinational; unused slots are zero.
module spicmd_pack
    import spicmd_pkg::*;
(
    input  layout_e            layout,
    input  logic [BYTE_W-1:0]  op,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [WORD_W-1:0]  data,
    input  logic [SIZE_W-1:0]  size,
    input  logic               clockless,
    output frame_t             fields,
    output logic [IDX_W-1:0]   field_len
);
    localparam int ADDR_BYTES = ADDR_W / BYTE_W;

    logic [BYTE_W-1:0] int_hi;

    // High internal-address byte with the clockless marker in bit 7.
    always_comb int_hi = {addr[15] | clockless, addr[14:8]};

    // Pack fields for the selected layout.
    always_comb begin
        fields    = '0;
        fields[0] = op;
        field_len = IDX_W'(4);
        unique case (layout)
            LAY_ADDR24, LAY_DMA16, LAY_DMA24, LAY_SGL_WR: begin
                for (int i = 0; i < ADDR_BYTES; i++)
                    fields[1+i] = addr[ADDR_W-1-BYTE_W*i -: BYTE_W];
                if (layout == LAY_DMA16) begin
                    fields[4] = size[15:8];
                    fields[5] = size[7:0];
                    field_len = IDX_W'(6);
                end else if (layout == LAY_DMA24) begin
                    for (int i = 0; i < 3; i++)
                        fields[4+i] = size[SIZE_W-1-BYTE_W*i -: BYTE_W];
                    field_len = IDX_W'(7);
                end else if (layout == LAY_SGL_WR) begin
                    for (int i = 0; i < WORD_BYTES; i++)
                        fields[4+i] = data[WORD_W-1-BYTE_W*i -: BYTE_W];
                    field_len = IDX_W'(8);
                end
            end
            LAY_INT_RD: begin
                fields[1] = int_hi;
                fields[2] = addr[7:0];
                fields[3] = 8'h00;
            end
            LAY_INT_WR: begin
                fields[1] = int_hi;
                fields[2] = addr[7:0];
                for (int i = 0; i < WORD_BYTES; i++)
                    fields[3+i] = data[WORD_W-1-BYTE_W*i -: BYTE_W];
                field_len = IDX_W'(7);
            end
            LAY_ZERO3: begin
                for (int i = 1; i < 4; i++) fields[i] = 8'h00;
            end
            LAY_ONES3: begin
                for (int i = 1; i < 4; i++) fields[i] = 8'hFF;
            end
            default: field_len = IDX_W'(4);
        endcase
    end
endmodule

// File: rtl/spicmd_crc7.sv
// CRC7 accumulator, generator x^7+x^3+1, MSB first, one byte per enable.
// Assumes: clear has priority over update; reset loads the seed.
module spicmd_crc7
    import spicmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              upd,
    input  logic [BYTE_W-1:0] din,
    output logic [CRC_W-1:0]  crc_q
);
    logic [CRC_W-1:0] crc_nx;

    // Walk the eight input bits through the LFSR, high bit first.
    always_comb begin
        logic fb;
        crc_nx = crc_q;
        for (int b = BYTE_W - 1; b >= 0; b--) begin
            fb     = crc_nx[CRC_W-1] ^ din[b];
            crc_nx = {crc_nx[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
    end

    // Hold, reseed, or advance the CRC register.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) crc_q <= CRC_SEED;
        else if (upd)        crc_q <= crc_nx;
    end

    AST_CRC_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> crc_q == CRC_SEED);                                   // R6
    AST_CRC_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !upd) |=> $stable(crc_q));                           // R9
endmodule

// File: rtl/spicmd_frame_enc.sv
// SPI command frame encoder top: accepts a command when idle, decodes and packs
// it, then streams field bytes and an optional CRC7 byte over valid/ready.
// Assumes: byte_ready may stall on any cycle; unsupported opcodes are dropped
// with a one-cycle cmd_err pulse.
module spicmd_frame_enc
    import spicmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [7:0]        cmd_op,
    input  logic [23:0]       cmd_addr,
    input  logic [31:0]       cmd_data,
    input  logic [23:0]       cmd_size,
    input  logic              cmd_clockless,
    input  logic              cmd_crc_en,
    output logic              cmd_err,
    output logic              byte_valid,
    input  logic              byte_ready,
    output logic [7:0]        byte_data,
    output logic              byte_last,
    output logic              frame_done
);
    typedef enum logic {ST_IDLE, ST_SEND} state_e;

    state_e           state_q;
    layout_e          layout;
    logic             known;
    frame_t           fields;
    logic [IDX_W-1:0] field_len;
    frame_t           frame_q;
    logic [IDX_W-1:0] len_q;
    logic [IDX_W-1:0] idx_q;
    logic             crc_on_q;
    logic             done_q;
    logic             err_q;
    logic [CRC_W-1:0] crc_q;
    logic             take;
    logic             hs;
    logic             at_end;
    logic             at_crc;

    spicmd_opdec u_dec (
        .op     (cmd_op),
        .layout (layout),
        .known  (known)
    );

    spicmd_pack u_pack (
        .layout    (layout),
        .op        (cmd_op),
        .addr      (cmd_addr),
        .data      (cmd_data),
        .size      (cmd_size),
        .clockless (cmd_clockless),
        .fields    (fields),
        .field_len (field_len)
    );

    // Handshake and position decode.
    always_comb begin
        take   = cmd_valid && (state_q == ST_IDLE);
        hs     = (state_q == ST_SEND) && byte_ready;
        at_end = (idx_q == len_q - IDX_W'(1));
        at_crc = crc_on_q && at_end;
    end

    spicmd_crc7 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (take),
        .upd   (hs && !at_crc),
        .din   (frame_q[idx_q]),
        .crc_q (crc_q)
    );

    // Frame state, byte index and latched frame contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            frame_q  <= '0;
            len_q    <= '0;
            idx_q    <= '0;
            crc_on_q <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (take) begin
                if (known) begin
                    frame_q  <= fields;
                    len_q    <= field_len + IDX_W'(cmd_crc_en);
                    crc_on_q <= cmd_crc_en;
                    idx_q    <= '0;
                    state_q  <= ST_SEND;
                end else begin
                    err_q <= 1'b1;
                end
            end else if (hs) begin
                if (at_end) begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                end else begin
                    idx_q <= idx_q + IDX_W'(1);
                end
            end
        end
    end

    // Output drive: the field byte, or the CRC byte in the last slot.
    always_comb begin
        cmd_ready  = (state_q == ST_IDLE);
        byte_valid = (state_q == ST_SEND);
        byte_last  = byte_valid && at_end;
        byte_data  = at_crc ? {crc_q, 1'b0} : frame_q[idx_q];
        frame_done = done_q;
        cmd_err    = err_q;
    end

    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready || cmd_err);            // R1
    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !byte_ready) |=> byte_valid && $stable(byte_data) && $stable(byte_last)); // R9
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && byte_ready && byte_last) |=> frame_done && !byte_valid); // R10
    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> !byte_valid && cmd_ready && !frame_done);           // R8
    AST_FIRST_IS_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(byte_valid) |-> byte_data[7:4] == 4'hC);                  // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);                                    // R10
endmodule

// File: tb/spicmd_frame_enc_test.sv
module spicmd_frame_enc_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [7:0]  cmd_op = '0;
    logic [23:0] cmd_addr = '0;
    logic [31:0] cmd_data = '0;
    logic [23:0] cmd_size = '0;
    logic        cmd_clockless = 1'b0;
    logic        cmd_crc_en = 1'b0;
    logic        cmd_err;
    logic        byte_valid;
    logic        byte_ready = 1'b0;
    logic [7:0]  byte_data;
    logic        byte_last;
    logic        frame_done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [7:0] exp_b [0:8];
    int exp_n;

    always #2 clk = ~clk;

    spicmd_frame_enc uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_size(cmd_size),
        .cmd_clockless(cmd_clockless), .cmd_crc_en(cmd_crc_en), .cmd_err(cmd_err),
        .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
        .byte_last(byte_last), .frame_done(frame_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] crc7_of(input int n);
        logic [6:0] c = 7'h7F;
        for (int k = 0; k < n; k++)
            for (int b = 7; b >= 0; b--) begin
                logic f = c[6] ^ exp_b[k][b];
                c = {c[5:0], 1'b0} ^ (f ? 7'h09 : 7'h00);
            end
        return c;
    endfunction

    // Expected frame built from the layout rules of R2..R7.
    task automatic build(input logic [7:0] op, input logic [23:0] a, input logic [31:0] d,
                         input logic [23:0] s, input logic cl, input logic crc);
        logic [7:0] ih = {a[15] | cl, a[14:8]};
        for (int k = 0; k < 9; k++) exp_b[k] = 8'h00;
        exp_b[0] = op;
        case (op)
            8'hCA: begin exp_b[1]=a[23:16]; exp_b[2]=a[15:8]; exp_b[3]=a[7:0]; exp_n=4; end
            8'hC9: begin exp_b[1]=a[23:16]; exp_b[2]=a[15:8]; exp_b[3]=a[7:0];
                         exp_b[4]=d[31:24]; exp_b[5]=d[23:16]; exp_b[6]=d[15:8]; exp_b[7]=d[7:0]; exp_n=8; end
            8'hC4: begin exp_b[1]=ih; exp_b[2]=a[7:0]; exp_b[3]=8'h00; exp_n=4; end
            8'hC3: begin exp_b[1]=ih; exp_b[2]=a[7:0];
                         exp_b[3]=d[31:24]; exp_b[4]=d[23:16]; exp_b[5]=d[15:8]; exp_b[6]=d[7:0]; exp_n=7; end
            8'hC5, 8'hC6: exp_n = 4;
            8'hCF: begin exp_b[1]=8'hFF; exp_b[2]=8'hFF; exp_b[3]=8'hFF; exp_n=4; end
            8'hC1, 8'hC2: begin exp_b[1]=a[23:16]; exp_b[2]=a[15:8]; exp_b[3]=a[7:0];
                         exp_b[4]=s[15:8]; exp_b[5]=s[7:0]; exp_n=6; end
            default: begin exp_b[1]=a[23:16]; exp_b[2]=a[15:8]; exp_b[3]=a[7:0];
                         exp_b[4]=s[23:16]; exp_b[5]=s[15:8]; exp_b[6]=s[7:0]; exp_n=7; end
        endcase
        if (crc) begin
            exp_b[exp_n] = {crc7_of(exp_n), 1'b0};
            exp_n++;
        end
    endtask

    // Drive one command and collect its frame, optionally stalling byte_ready.
    task automatic run_frame(input string req, input logic [7:0] op, input logic [23:0] a,
                             input logic [31:0] d, input logic [23:0] s, input logic cl,
                             input logic crc, input int stall);
        int got = 0;
        int cyc = 0;
        logic held_v = 1'b0;
        logic [7:0] held_d = '0;
        build(op, a, d, s, cl, crc);
        @(negedge clk);
        chk({"R1 ready before ", req}, {31'b0, cmd_ready}, 32'd1);
        cmd_op = op; cmd_addr = a; cmd_data = d; cmd_size = s;
        cmd_clockless = cl; cmd_crc_en = crc; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (got < exp_n && cyc < 100) begin
            logic rdy = (stall == 0) ? 1'b1 : ((cyc % 3) != 1);
            if (got == exp_n - 1 && stall != 0 && !held_v) rdy = 1'b0;
            if (held_v) begin
                chk({"R9 hold ", req}, {24'b0, byte_data}, {24'b0, held_d});
            end
            if (byte_valid !== 1'b1 || cmd_ready !== 1'b0) begin
                chk({"R1 busy ", req}, {30'b0, byte_valid, cmd_ready}, 32'd2);
            end
            byte_ready = rdy;
            if (rdy && byte_valid) begin
                chk({req, " byte"}, {24'b0, byte_data}, {24'b0, exp_b[got]});
                chk({"R10 last ", req}, {31'b0, byte_last}, {31'b0, (got == exp_n - 1)});
                got++;
                held_v = 1'b0;
            end else begin
                held_v = byte_valid;
                held_d = byte_data;
            end
            cyc++;
            @(negedge clk);
        end
        byte_ready = 1'b0;
        chk({"R10 done ", req}, {30'b0, frame_done, byte_valid}, 32'd2);
        @(negedge clk);
        chk({"R10 done one cycle ", req}, {31'b0, frame_done}, 32'd0);
    endtask

    task automatic bad_op(input logic [7:0] op);
        @(negedge clk);
        cmd_op = op; cmd_crc_en = 1'b1; cmd_valid = 1'b1; byte_ready = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R8 err pulse", {29'b0, cmd_err, byte_valid, cmd_ready}, 32'd5);
        @(negedge clk);
        chk("R8 err cleared, silent", {29'b0, cmd_err, byte_valid, cmd_ready}, 32'd1);
        byte_ready = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset", {27'b0, cmd_ready, byte_valid, byte_last, frame_done, cmd_err}, 32'h10);
        rst_n = 1'b1;
        run_frame("R2 single read crc", 8'hCA, 24'h123456, 0, 0, 0, 1, 0);
        run_frame("R7 single read no crc", 8'hCA, 24'hA5C301, 0, 0, 0, 0, 0);
        run_frame("R2 single write stall", 8'hC9, 24'h00FF10, 32'hDEADBEEF, 0, 0, 1, 1);
        run_frame("R3 internal read clockless", 8'hC4, 24'h000024, 0, 0, 1, 1, 0);
        run_frame("R3 internal read normal", 8'hC4, 24'h771234, 0, 0, 0, 1, 1);
        run_frame("R3 internal read bit15 set", 8'hC4, 24'h00F0AA, 0, 0, 1, 1, 0);
        run_frame("R3 internal write nocrc", 8'hC3, 24'h000010, 32'h01234567, 0, 1, 0, 1);
        run_frame("R4 terminate", 8'hC5, 24'hFFFFFF, 32'hFFFFFFFF, 24'hFFFFFF, 1, 1, 0);
        run_frame("R4 repeat", 8'hC6, 24'h111111, 0, 0, 0, 1, 1);
        run_frame("R4 reset", 8'hCF, 24'h000000, 0, 0, 0, 1, 0);
        run_frame("R5 dma write", 8'hC1, 24'h0A0B0C, 0, 24'h012345, 0, 1, 0);
        run_frame("R5 dma read nocrc", 8'hC2, 24'h800000, 0, 24'hFF00FF, 0, 0, 1);
        run_frame("R5 ext dma write", 8'hC7, 24'h102030, 0, 24'hABCDEF, 0, 1, 1);
        run_frame("R6 ext dma read", 8'hC8, 24'h445566, 0, 24'h000800, 1, 1, 0);
        bad_op(8'hC0);
        bad_op(8'hCB);
        bad_op(8'hCE);
        run_frame("R6 after error", 8'hC9, 24'h55AA55, 32'h80000001, 0, 0, 1, 0);
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule